// File: doc/BRIEF.md
# Host Report Register Bridge

This block sits between a host report channel and the control logic of an audio device. Each 32-bit output report carries a command, and the block decodes it. A command can write or read one of four 16-bit control registers. It can also write or read one 16-bit word of an external serial memory through a request/acknowledge port. Every answer to the host goes out as a 24-bit input report. Its low byte names the source of the word with a one-hot flag and also carries live status from the front-panel buttons and the headphone jack.

An attached controller can push its own 16-bit word into the input report. The playback-mute button produces a sticky flag, and that flag stays set until the host collects a report. All three button inputs are active low. Each passes through a synchronizer and a sample-agreement filter before the block uses it.

Top module: `hid_reg_bridge`

## Requirements
- R1: After reset the registers hold 0x0000, 0xB000 and 0x0004 (indices 0 to 2). Register 3 reads 0x003F when `pkg_sel_i` is 0 and 0x007F when it is 1, with `spdif_rate_i`=0 and `rec_ok_i`=1. `in_valid_o` and `mem_req_o` are low.
- R2: An output report with opcode byte (bits 7:0) 32 and address byte (bits 31:24) 0 to 3 writes the register. Bits 15:8 become its low byte and bits 23:16 its high byte.
- R3: Opcode 48 loads the addressed register word into `in_data_o[23:8]`, sets only the register flag (`in_data_o[4]`) and raises `in_valid_o` on the next cycle.
- R4: A register write with an address of 4 or more changes no register.
- R5: In register 3, bits 8:7 show `spdif_rate_i`, bit 6 shows `pkg_sel_i` and bit 0 shows `rec_ok_i`. Writes to these bits are ignored. Bits 10:9 and 5:1 are writable and all other bits read 0.
- R6: Opcode 64 with an address of 0 to 63 raises `mem_req_o` with `mem_we_o`=1 and the address and data. These are held until `mem_ack_i`, and no report is produced.
- R7: Opcode 80 requests a memory read. On `mem_ack_i` the block loads `mem_rdata_i` into the report with only the memory flag (`in_data_o[5]`) set.
- R8: `mcu_valid_i` loads `mcu_data_i` into the report with only the controller flag (`in_data_o[6]`) set.
- R9: `in_ack_i` clears `in_valid_o` and all source flags. When a new report is loaded in the same cycle, the new report stays pending.
- R10: `in_data_o[0]` is 1 while `vol_up_ni` is held low, and `in_data_o[1]` is 1 while `vol_dn_ni` is held low.
- R11: A press of `mute_ni` sets `in_data_o[2]`. The bit stays set after release and clears on `in_ack_i`.
- R12: `in_data_o[3]` follows `phone_sense_i` after a two-stage synchronizer.
- R13: A button low for fewer than 3 consecutive samples has no effect.
- R14: Unknown opcodes and memory commands with an address above 63 produce no report, no memory request and no register change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| out_valid_i | input | 1 | Output report strobe |
| out_data_i | input | 32 | Output report: opcode, low, high, address bytes |
| in_valid_o | output | 1 | Input report pending |
| in_data_o | output | 24 | Input report: header byte, low, high data |
| in_ack_i | input | 1 | Host has read the input report |
| mcu_valid_i | input | 1 | Controller word strobe |
| mcu_data_i | input | 16 | Controller word |
| mem_req_o | output | 1 | Serial memory request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | 6 | Memory word address |
| mem_wdata_o | output | 16 | Memory write word |
| mem_ack_i | input | 1 | Memory request done |
| mem_rdata_i | input | 16 | Memory read word |
| vol_up_ni | input | 1 | Volume-up button, active low |
| vol_dn_ni | input | 1 | Volume-down button, active low |
| mute_ni | input | 1 | Playback-mute button, active low |
| phone_sense_i | input | 1 | Headphone plugged |
| pkg_sel_i | input | 1 | Package select status |
| spdif_rate_i | input | 2 | Incoming digital-audio rate code |
| rec_ok_i | input | 1 | Recording permitted status |
| cfg_o | output | 64 | Registers 0 to 3, register n at bits 16n+15:16n |

## Verification
The host acknowledge and a new report load can land in the same clock cycle. In that case clearing the pending report competes with filling it. The bench provokes this by holding back its automatic acknowledge while a register read is pending. It then drives `in_ack_i` and `mcu_valid_i` together on one edge. The check passes if `in_valid_o` is still high on the next cycle and the report carries the controller word with only the controller flag set. A later lone acknowledge must leave the flags clear.

// File: rtl/hid_bridge_pkg.sv
package hid_bridge_pkg;
  localparam int REG_W    = 16;
  localparam int STAT_IDX = 3;

  typedef enum logic [7:0] {
    OP_REG_WR = 8'd32,
    OP_REG_RD = 8'd48,
    OP_MEM_WR = 8'd64,
    OP_MEM_RD = 8'd80
  } opcode_e;

  // source flag positions inside src vector (header bits 4..6)
  localparam int SRC_REG = 0;
  localparam int SRC_MEM = 1;
  localparam int SRC_MCU = 2;

  localparam logic [REG_W-1:0] STAT_WMASK = 16'h063E;

  function automatic logic [REG_W-1:0] reg_rst(int idx);
    case (idx)
      0:       return 16'h0000;
      1:       return 16'hB000;
      2:       return 16'h0004;
      default: return 16'h003E;
    endcase
  endfunction

  function automatic logic [REG_W-1:0] reg_wmask(int idx);
    return (idx == STAT_IDX) ? STAT_WMASK : '1;
  endfunction
endpackage

// File: rtl/hid_btn_filter.sv
module hid_btn_filter #(
  parameter int SAMPLES = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_ni,
  output logic level_o,
  output logic press_o
);
  logic [1:0]         sync_q;
  logic [SAMPLES-1:0] hist_q;
  logic               level_q, press_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q  <= '0;
      hist_q  <= '0;
      level_q <= 1'b0;
      press_q <= 1'b0;
    end else begin
      sync_q  <= {sync_q[0], ~raw_ni};
      hist_q  <= {hist_q[SAMPLES-2:0], sync_q[1]};
      press_q <= (&hist_q) & ~level_q;
      if (&hist_q)       level_q <= 1'b1;
      else if (~|hist_q) level_q <= 1'b0;
    end
  end

  assign level_o = level_q;
  assign press_o = press_q;

  // R13
  filt_agree_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(level_q) |-> $past(&hist_q));
endmodule

// File: rtl/hid_reg_bank.sv
module hid_reg_bank
  import hid_bridge_pkg::*;
#(
  parameter int NREG = 4,
  localparam int IDXW = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [IDXW-1:0]       idx_i,
  input  logic [REG_W-1:0]      wdata_i,
  input  logic [1:0]            rate_i,
  input  logic                  pkg_i,
  input  logic                  rec_i,
  output logic [REG_W-1:0]      rd_data_o,
  output logic [NREG*REG_W-1:0] cfg_o
);
  logic [NREG-1:0][REG_W-1:0] store_q;
  logic [NREG-1:0][REG_W-1:0] view;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        store_q[g] <= reg_rst(g);
      else if (wr_en_i && idx_i == IDXW'(g))
        store_q[g] <= wdata_i & reg_wmask(g);
    end

    if (g == STAT_IDX) begin : g_stat
      assign view[g] = store_q[g] | {7'b0, rate_i, pkg_i, 5'b0, rec_i};
    end else begin : g_plain
      assign view[g] = store_q[g];
    end
    assign cfg_o[g*REG_W +: REG_W] = view[g];
  end

  assign rd_data_o = view[idx_i];

  // R4
  no_stray_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(store_q));
endmodule

// File: rtl/hid_reg_bridge.sv
module hid_reg_bridge
  import hid_bridge_pkg::*;
#(
  parameter int NREG       = 4,
  parameter int MEM_AW     = 6,
  parameter int DB_SAMPLES = 3
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  out_valid_i,
  input  logic [31:0]           out_data_i,
  output logic                  in_valid_o,
  output logic [23:0]           in_data_o,
  input  logic                  in_ack_i,
  input  logic                  mcu_valid_i,
  input  logic [REG_W-1:0]      mcu_data_i,
  output logic                  mem_req_o,
  output logic                  mem_we_o,
  output logic [MEM_AW-1:0]     mem_addr_o,
  output logic [REG_W-1:0]      mem_wdata_o,
  input  logic                  mem_ack_i,
  input  logic [REG_W-1:0]      mem_rdata_i,
  input  logic                  vol_up_ni,
  input  logic                  vol_dn_ni,
  input  logic                  mute_ni,
  input  logic                  phone_sense_i,
  input  logic                  pkg_sel_i,
  input  logic [1:0]            spdif_rate_i,
  input  logic                  rec_ok_i,
  output logic [NREG*REG_W-1:0] cfg_o
);
  localparam int IDXW  = (NREG > 1) ? $clog2(NREG) : 1;
  localparam int NBTN  = 3;
  localparam int B_UP  = 0;
  localparam int B_DN  = 1;
  localparam int B_MUT = 2;

  // ---- button and jack conditioning
  logic [NBTN-1:0] btn_raw, btn_lvl, btn_press;
  assign btn_raw = {mute_ni, vol_dn_ni, vol_up_ni};

  for (genvar b = 0; b < NBTN; b++) begin : g_btn
    hid_btn_filter #(.SAMPLES(DB_SAMPLES)) u_filt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .raw_ni (btn_raw[b]),
      .level_o(btn_lvl[b]),
      .press_o(btn_press[b])
    );
  end

  logic [1:0] jack_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) jack_q <= '0;
    else         jack_q <= {jack_q[0], phone_sense_i};
  end

  // ---- command decode
  logic [7:0]       op, adr;
  logic [REG_W-1:0] cmd_word;
  logic             reg_hit, mem_hit;
  logic             wr_en, rd_cmd, mem_cmd;

  assign op       = out_data_i[7:0];
  assign cmd_word = out_data_i[23:8];
  assign adr      = out_data_i[31:24];
  assign reg_hit  = int'(adr) < NREG;
  assign mem_hit  = (adr >> MEM_AW) == 8'd0;

  assign wr_en   = out_valid_i && op == OP_REG_WR && reg_hit;
  assign rd_cmd  = out_valid_i && op == OP_REG_RD;
  assign mem_cmd = out_valid_i && (op == OP_MEM_WR || op == OP_MEM_RD)
                   && mem_hit && !mem_req_o;

  logic [REG_W-1:0] rd_data;

  hid_reg_bank #(.NREG(NREG)) u_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en),
    .idx_i    (adr[IDXW-1:0]),
    .wdata_i  (cmd_word),
    .rate_i   (spdif_rate_i),
    .pkg_i    (pkg_sel_i),
    .rec_i    (rec_ok_i),
    .rd_data_o(rd_data),
    .cfg_o    (cfg_o)
  );

  // ---- serial memory handshake
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_req_o   <= 1'b0;
      mem_we_o    <= 1'b0;
      mem_addr_o  <= '0;
      mem_wdata_o <= '0;
    end else if (mem_cmd) begin
      mem_req_o   <= 1'b1;
      mem_we_o    <= (op == OP_MEM_WR);
      mem_addr_o  <= adr[MEM_AW-1:0];
      mem_wdata_o <= cmd_word;
    end else if (mem_ack_i) begin
      mem_req_o   <= 1'b0;
    end
  end

  // ---- input report
  logic             mem_done, load;
  logic             pend_q, mute_q;
  logic [2:0]       src_q, src_nx;
  logic [REG_W-1:0] word_q, word_nx;

  assign mem_done = mem_req_o && mem_ack_i && !mem_we_o;
  assign load     = mem_done || rd_cmd || mcu_valid_i;

  // priority: memory answer, register read, controller word
  always_comb begin
    src_nx  = '0;
    word_nx = mcu_data_i;
    if (mem_done) begin
      src_nx[SRC_MEM] = 1'b1;
      word_nx         = mem_rdata_i;
    end else if (rd_cmd) begin
      src_nx[SRC_REG] = 1'b1;
      word_nx         = reg_hit ? rd_data : '0;
    end else begin
      src_nx[SRC_MCU] = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      src_q  <= '0;
      word_q <= '0;
    end else if (load) begin
      pend_q <= 1'b1;
      src_q  <= src_nx;
      word_q <= word_nx;
    end else if (in_ack_i) begin
      pend_q <= 1'b0;
      src_q  <= '0;
    end
  end

  // press wins over a coincident host read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                mute_q <= 1'b0;
    else if (btn_press[B_MUT])  mute_q <= 1'b1;
    else if (in_ack_i)          mute_q <= 1'b0;
  end

  assign in_valid_o = pend_q;
  assign in_data_o  = {word_q, 1'b0, src_q[SRC_MCU], src_q[SRC_MEM], src_q[SRC_REG],
                       jack_q[1], mute_q, btn_lvl[B_DN], btn_lvl[B_UP]};

  // R3
  src_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(in_data_o[6:4]));
  // R9
  ack_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ack_i && !load |=> !in_valid_o && in_data_o[6:4] == 3'b000);
  // R6
  mem_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)
                                 && $stable(mem_wdata_o));
  // R11
  mute_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    btn_press[B_MUT] |=> in_data_o[2]);
endmodule

// File: tb/hid_reg_bridge_tb.sv
`timescale 1ns/1ps
module hid_reg_bridge_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        out_valid = 1'b0;
  logic [31:0] out_data = '0;
  logic        in_valid;
  logic [23:0] in_data;
  logic        mon_ack = 1'b0, man_ack = 1'b0;
  logic        mcu_valid = 1'b0;
  logic [15:0] mcu_data = '0;
  logic        mem_req, mem_we;
  logic [5:0]  mem_addr;
  logic [15:0] mem_wdata;
  logic        mem_ack = 1'b0;
  logic [15:0] mem_rdata = '0;
  logic        vup_n = 1'b1, vdn_n = 1'b1, mute_n = 1'b1, jack = 1'b0;
  logic        pkg = 1'b0, rec = 1'b1;
  logic [1:0]  rate = 2'b00;
  logic [63:0] cfg;

  always #4 clk = ~clk;

  hid_reg_bridge dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .out_valid_i(out_valid), .out_data_i(out_data),
    .in_valid_o(in_valid), .in_data_o(in_data), .in_ack_i(mon_ack | man_ack),
    .mcu_valid_i(mcu_valid), .mcu_data_i(mcu_data),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
    .vol_up_ni(vup_n), .vol_dn_ni(vdn_n), .mute_ni(mute_n),
    .phone_sense_i(jack), .pkg_sel_i(pkg), .spdif_rate_i(rate), .rec_ok_i(rec),
    .cfg_o(cfg)
  );

  int n_vec = 0, n_bad = 0;
  bit mon_hold = 1'b0, done = 1'b0, seen_req = 1'b0;
  logic [19:0] exp_q[$];
  logic [15:0] mem_img [64];
  int mem_cnt = 0;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] reg_of(int i);
    return cfg[i*16 +: 16];
  endfunction

  // driver: push expected report, then apply command
  task automatic host_cmd(logic [7:0] op, logic [15:0] w, logic [7:0] a,
                          bit expect_rpt, logic [15:0] ew, logic [2:0] esrc);
    if (expect_rpt) exp_q.push_back({ew, 1'b0, esrc});
    @(negedge clk);
    out_valid = 1'b1;
    out_data  = {a, w, op};
    @(negedge clk);
    out_valid = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  // monitor: compare each report and acknowledge it
  always @(negedge clk) begin
    if (in_valid && !mon_hold && !mon_ack) begin
      n_vec++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R3/R7/R8: actual report %h expected none", in_data);
      end else begin
        logic [19:0] e;
        e = exp_q.pop_front();
        if (in_data[23:4] !== e) begin
          n_bad++;
          $display("FAIL R3/R7/R8: actual %h expected %h", in_data[23:4], e);
        end
      end
      mon_ack = 1'b1;
    end else begin
      mon_ack = 1'b0;
    end
  end

  // serial memory model: acknowledge after three sampling edges
  always @(negedge clk) begin
    if (mem_req) begin
      seen_req = 1'b1;
      if (mem_cnt == 2) begin
        if (mem_we) mem_img[mem_addr] = mem_wdata;
        mem_rdata = mem_img[mem_addr];
        mem_ack   = 1'b1;
        mem_cnt   = 0;
      end else begin
        mem_ack = 1'b0;
        mem_cnt++;
      end
    end else begin
      mem_ack = 1'b0;
      mem_cnt = 0;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] snap;
    bit glitch;
    for (int i = 0; i < 64; i++) mem_img[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 reg0", reg_of(0), 16'h0000);
    check("R1 reg1", reg_of(1), 16'hB000);
    check("R1 reg2", reg_of(2), 16'h0004);
    check("R1 reg3 pkg0", reg_of(3), 16'h003F);
    check("R1 idle", {in_valid, mem_req}, 2'b00);
    pkg = 1'b1;
    @(negedge clk);
    check("R1 reg3 pkg1", reg_of(3), 16'h007F);
    pkg = 1'b0;

    // R3 register read
    host_cmd(8'd48, 16'h0, 8'd1, 1, 16'hB000, 3'b001);
    // R2 register write and read back
    host_cmd(8'd32, 16'h1234, 8'd2, 0, 0, 0);
    check("R2 reg2 write", reg_of(2), 16'h1234);
    host_cmd(8'd48, 16'h0, 8'd2, 1, 16'h1234, 3'b001);

    // R4 out-of-range write
    snap = cfg;
    host_cmd(8'd32, 16'hFFFF, 8'd4, 0, 0, 0);
    check("R4 no change", cfg[31:0], snap[31:0]);
    check("R4 no change hi", cfg[63:32], snap[63:32]);

    // R5 read-only bits in register 3
    rec = 1'b0;
    host_cmd(8'd32, 16'hFFFF, 8'd3, 0, 0, 0);
    check("R5 writable only", reg_of(3), 16'h063E);
    rate = 2'b10; pkg = 1'b1; rec = 1'b1;
    @(negedge clk);
    host_cmd(8'd48, 16'h0, 8'd3, 1, 16'h077F, 3'b001);
    pkg = 1'b0;

    // R6 memory write
    seen_req = 1'b0;
    host_cmd(8'd64, 16'hCAFE, 8'd5, 0, 0, 0);
    check("R6 mem stored", mem_img[5], 16'hCAFE);
    check("R6 req seen, released", {seen_req, mem_req}, 2'b10);
    // R7 memory read
    host_cmd(8'd80, 16'h0, 8'd5, 1, 16'hCAFE, 3'b010);
    // R8 controller word
    exp_q.push_back({16'h55AA, 4'b0100});
    @(negedge clk); mcu_valid = 1'b1; mcu_data = 16'h55AA;
    @(negedge clk); mcu_valid = 1'b0;
    repeat (4) @(negedge clk);
    check("R8 scoreboard drained", exp_q.size(), 0);

    // R9 acknowledge and new load in one cycle
    mon_hold = 1'b1;
    host_cmd(8'd48, 16'h0, 8'd0, 0, 0, 0);
    check("R9 pending before", in_valid, 1'b1);
    man_ack = 1'b1; mcu_valid = 1'b1; mcu_data = 16'hBEEF;
    @(negedge clk);
    man_ack = 1'b0; mcu_valid = 1'b0;
    check("R9 load wins", {in_valid, in_data[23:4]}, {1'b1, 16'hBEEF, 4'b0100});
    man_ack = 1'b1;
    @(negedge clk);
    man_ack = 1'b0;
    check("R9 cleared", {in_valid, in_data[6:4]}, 4'b0000);
    mon_hold = 1'b0;

    // R10 volume buttons held
    vup_n = 1'b0;
    repeat (10) @(negedge clk);
    check("R10 up held", in_data[1:0], 2'b01);
    vup_n = 1'b1; vdn_n = 1'b0;
    repeat (10) @(negedge clk);
    check("R10 down held", in_data[1:0], 2'b10);
    vdn_n = 1'b1;
    repeat (10) @(negedge clk);
    check("R10 released", in_data[1:0], 2'b00);

    // R13 short glitch ignored
    glitch = 1'b0;
    vup_n = 1'b0;
    repeat (2) @(negedge clk);
    vup_n = 1'b1;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (in_data[0]) glitch = 1'b1;
    end
    check("R13 glitch", glitch, 1'b0);

    // R11 sticky mute
    mute_n = 1'b0;
    repeat (10) @(negedge clk);
    mute_n = 1'b1;
    repeat (10) @(negedge clk);
    check("R11 mute sticky", in_data[2], 1'b1);
    host_cmd(8'd48, 16'h0, 8'd0, 1, 16'h0000, 3'b001);
    check("R11 mute cleared", in_data[2], 1'b0);

    // R12 jack sense
    jack = 1'b1;
    repeat (4) @(negedge clk);
    check("R12 jack on", in_data[3], 1'b1);
    jack = 1'b0;
    repeat (4) @(negedge clk);
    check("R12 jack off", in_data[3], 1'b0);

    // R14 unknown opcode and memory address above range
    snap = cfg;
    seen_req = 1'b0;
    host_cmd(8'd33, 16'hFFFF, 8'd0, 0, 0, 0);
    host_cmd(8'd80, 16'h0, 8'd64, 0, 0, 0);
    host_cmd(8'd64, 16'h1111, 8'd200, 0, 0, 0);
    check("R14 no mem request", seen_req, 1'b0);
    check("R14 regs kept", cfg[31:0], snap[31:0]);
    check("R14 no report", in_valid, 1'b0);
    check("R14 queue empty", exp_q.size(), 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule